// File: doc/BRIEF.md
# Multicycle Accumulator Processor Core

This block is a small processor built around one accumulator and a single shared internal bus. A control sequencer walks through one register transfer per clock. Each instruction is fetched in three cycles and then runs a fixed execute sequence chosen by its opcode. The sequence is one to six cycles long. In each cycle exactly one register drives the bus, and only registers whose load strobe is raised capture it.

The core drives a word-addressed memory with an address, a write-data word, a read strobe and a write strobe, and takes back one read-data word. The memory must present the addressed word on `mem_rdata` in the same cycle that `mem_rd` is high. The data register captures it on the clock edge that closes that cycle.

A program word carries a 4-bit opcode in bits [15:12] and a 12-bit operand address in bits [11:0] (default width). The core offers:
- load, store, add, subtract, NAND and a left shift of the accumulator;
- an unconditional jump and a branch taken when the zero flag is clear;
- two pointer-based loads: plain indirect, and indirect with a pre-decrement that is written back to memory.

Top module: `acc_core`

## Requirements
- R1: A synchronous reset clears the program counter, accumulator, zero flag and sequencer, and raises neither memory strobe. After release, cycle 0 makes no memory access and cycle 1 reads address 0.
- R2: Fetch takes three cycles. The first moves the program counter to the address register. The second reads memory and increments the program counter. The third splits the word: bits [15:12] go to the instruction register and bits [11:0] to the address register.
- R3: Opcode 0 (load) reads M[x] and then copies it to the accumulator, in two execute cycles. Opcode 1 (store) copies the accumulator to the data register and then writes M[x] in its second execute cycle. The first store in a program that starts with load x, store y writes in cycle 9 after reset.
- R4: Opcodes 2, 3 and 4 read M[x] in one cycle. In the next cycle they put AC+M[x], AC−M[x] or NOT(AC AND M[x]) into the accumulator, modulo 2^16. Opcode 5 shifts the accumulator left by one, inserts a zero, and takes one execute cycle.
- R5: The zero flag is set exactly when the last result of opcodes 2, 3, 4 or 5 was zero. All other opcodes leave it unchanged.
- R6: Opcode 6 loads the program counter from the address field in one execute cycle. Opcode 7 does the same only when the zero flag is clear, and otherwise leaves the program counter unchanged.
- R7: Opcode 8 reads a pointer from M[x], moves it to the address register, reads M[pointer] and loads it into the accumulator, in four execute cycles.
- R8: Opcode 9 reads the pointer from M[x] and decrements it in the data register. It writes the decremented pointer back to M[x] in its third execute cycle, then loads the accumulator from M[pointer−1]. It takes six execute cycles.
- R9: Opcodes 10 to 15 take one execute cycle, access no memory and change no register other than those written during fetch.
- R10: At most one source drives the internal bus in any cycle, and the read and write strobes are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 12 | Word address, taken from the address register |
| mem_rdata | input | 16 | Read word, valid in the cycle mem_rd is high |
| mem_wdata | output | 16 | Write word, taken from the data register |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |

## Verification
Each scenario runs a short program that ends in a jump to itself. Results are read back from the memory locations that the program stores to.

The load/store program pins down the exact cycle of the first memory read and of the first write. This separates a three-cycle fetch from any other length. The arithmetic program chains operands that wrap past 2^16, so the modular add, the subtract, NAND and the shift each give a distinct value.

The branch program counts a loop down to zero. It then loads a nonzero value and branches, which shows that loads leave the zero flag alone. The indirect, pre-decrement and unused-opcode programs check the pointer write-back value and cycle, the final data, and that unused opcodes only add time.

// File: rtl/acc_core_pkg.sv
package acc_core_pkg;

   localparam int OP_W   = 4;
   localparam int STEP_W = 3;

   localparam logic [OP_W-1:0] OPC_LOAD  = 4'd0;
   localparam logic [OP_W-1:0] OPC_STORE = 4'd1;
   localparam logic [OP_W-1:0] OPC_ADD   = 4'd2;
   localparam logic [OP_W-1:0] OPC_SUB   = 4'd3;
   localparam logic [OP_W-1:0] OPC_NAND  = 4'd4;
   localparam logic [OP_W-1:0] OPC_SHL   = 4'd5;
   localparam logic [OP_W-1:0] OPC_JUMP  = 4'd6;
   localparam logic [OP_W-1:0] OPC_BRNZ  = 4'd7;
   localparam logic [OP_W-1:0] OPC_LDIND = 4'd8;
   localparam logic [OP_W-1:0] OPC_LDDEC = 4'd9;

   // bus source indices (one-hot output enables)
   localparam int N_SRC   = 4;
   localparam int SRC_PC  = 0;
   localparam int SRC_MDR = 1;
   localparam int SRC_FLD = 2;
   localparam int SRC_ACC = 3;

   typedef enum logic [2:0] {
      ALU_PASS, ALU_ADD, ALU_SUB, ALU_NAND, ALU_SHL
   } alu_fn_e;

   typedef struct packed {
      logic [N_SRC-1:0] oe;
      logic    ld_mar;
      logic    ld_ir;
      logic    ld_pc;
      logic    br_nz;
      logic    inc_pc;
      logic    ld_acc;
      logic    ld_z;
      logic    mdr_bus;
      logic    mdr_mem;
      logic    mdr_dec;
      logic    rd;
      logic    wr;
      logic    done;
      alu_fn_e fn;
   } uop_t;

endpackage

// File: rtl/acc_core_alu.sv
module acc_core_alu
   import acc_core_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  alu_fn_e           fn,
   output logic [DATA_W-1:0] y
);

   always_comb begin
      unique case (fn)
         ALU_ADD:  y = a + b;
         ALU_SUB:  y = a - b;
         ALU_NAND: y = ~(a & b);
         ALU_SHL:  y = {a[DATA_W-2:0], 1'b0};
         default:  y = b;
      endcase
   end

endmodule

// File: rtl/acc_core_ctrl.sv
module acc_core_ctrl
   import acc_core_pkg::*;
(
   input  logic            clk,
   input  logic            rst,
   input  logic [OP_W-1:0] opcode,
   output uop_t            uop
);

   typedef enum logic [1:0] {PH_ADR, PH_RD, PH_DEC, PH_EXE} phase_e;

   phase_e            phase;
   logic [STEP_W-1:0] step;

   always_ff @(posedge clk) begin
      if (rst) begin
         phase <= PH_ADR;
         step  <= '0;
      end else begin
         unique case (phase)
            PH_ADR: phase <= PH_RD;
            PH_RD:  phase <= PH_DEC;
            PH_DEC: phase <= PH_EXE;
            default: begin
               if (uop.done) begin
                  phase <= PH_ADR;
                  step  <= '0;
               end else begin
                  step <= step + 1'b1;
               end
            end
         endcase
      end
   end

   always_comb begin
      uop    = '0;
      uop.fn = ALU_PASS;
      unique case (phase)
         PH_ADR: begin
            uop.oe[SRC_PC] = 1'b1;
            uop.ld_mar     = 1'b1;
         end
         PH_RD: begin
            uop.rd      = 1'b1;
            uop.mdr_mem = 1'b1;
            uop.inc_pc  = 1'b1;
         end
         PH_DEC: begin
            uop.oe[SRC_MDR] = 1'b1;
            uop.ld_ir       = 1'b1;
            uop.ld_mar      = 1'b1;
         end
         default: begin
            unique case (opcode)
               OPC_LOAD: begin
                  if (step == 0) begin
                     uop.rd = 1'b1; uop.mdr_mem = 1'b1;
                  end else begin
                     uop.oe[SRC_MDR] = 1'b1; uop.ld_acc = 1'b1; uop.done = 1'b1;
                  end
               end
               OPC_STORE: begin
                  if (step == 0) begin
                     uop.oe[SRC_ACC] = 1'b1; uop.mdr_bus = 1'b1;
                  end else begin
                     uop.wr = 1'b1; uop.done = 1'b1;
                  end
               end
               OPC_ADD, OPC_SUB, OPC_NAND: begin
                  if (step == 0) begin
                     uop.rd = 1'b1; uop.mdr_mem = 1'b1;
                  end else begin
                     uop.oe[SRC_MDR] = 1'b1; uop.ld_acc = 1'b1; uop.ld_z = 1'b1;
                     uop.done = 1'b1;
                     uop.fn = (opcode == OPC_ADD) ? ALU_ADD :
                              (opcode == OPC_SUB) ? ALU_SUB : ALU_NAND;
                  end
               end
               OPC_SHL: begin
                  uop.fn = ALU_SHL; uop.ld_acc = 1'b1; uop.ld_z = 1'b1; uop.done = 1'b1;
               end
               OPC_JUMP, OPC_BRNZ: begin
                  uop.oe[SRC_FLD] = 1'b1; uop.ld_pc = 1'b1; uop.done = 1'b1;
                  uop.br_nz = (opcode == OPC_BRNZ);
               end
               OPC_LDIND: begin
                  unique case (step)
                     3'd0, 3'd2: begin uop.rd = 1'b1; uop.mdr_mem = 1'b1; end
                     3'd1: begin uop.oe[SRC_MDR] = 1'b1; uop.ld_mar = 1'b1; end
                     default: begin
                        uop.oe[SRC_MDR] = 1'b1; uop.ld_acc = 1'b1; uop.done = 1'b1;
                     end
                  endcase
               end
               OPC_LDDEC: begin
                  unique case (step)
                     3'd0, 3'd4: begin uop.rd = 1'b1; uop.mdr_mem = 1'b1; end
                     3'd1: uop.mdr_dec = 1'b1;
                     3'd2: uop.wr = 1'b1;
                     3'd3: begin uop.oe[SRC_MDR] = 1'b1; uop.ld_mar = 1'b1; end
                     default: begin
                        uop.oe[SRC_MDR] = 1'b1; uop.ld_acc = 1'b1; uop.done = 1'b1;
                     end
                  endcase
               end
               default: uop.done = 1'b1;
            endcase
         end
      endcase
   end

   // an execute sequence never outlives the longest opcode
   p_step_bound_r8: assert property (@(posedge clk) disable iff (rst)
      (phase == PH_EXE) |-> (step <= 3'd5));

endmodule

// File: rtl/acc_core_dp.sv
module acc_core_dp
   import acc_core_pkg::*;
#(
   parameter  int DATA_W = 16,
   localparam int ADDR_W = DATA_W - OP_W
) (
   input  logic              clk,
   input  logic              rst,
   input  uop_t              uop,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic [OP_W-1:0]   opcode
);

   localparam int PAD_W = DATA_W - ADDR_W;

   logic [ADDR_W-1:0] pc, mar;
   logic [DATA_W-1:0] mdr, acc, bus, alu_y;
   logic [OP_W-1:0]   ir;
   logic              zf;
   logic [DATA_W-1:0] src [N_SRC];

   assign src[SRC_PC]  = {{PAD_W{1'b0}}, pc};
   assign src[SRC_MDR] = mdr;
   assign src[SRC_FLD] = {{PAD_W{1'b0}}, mdr[ADDR_W-1:0]};
   assign src[SRC_ACC] = acc;

   // AND-OR bus: each source gated by its own output enable
   always_comb begin
      bus = '0;
      for (int i = 0; i < N_SRC; i++)
         bus |= src[i] & {DATA_W{uop.oe[i]}};
   end

   acc_core_alu #(.DATA_W(DATA_W)) u_alu (
      .a  (acc),
      .b  (bus),
      .fn (uop.fn),
      .y  (alu_y)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         pc  <= '0;
         acc <= '0;
         zf  <= 1'b0;
         mar <= '0;
         mdr <= '0;
         ir  <= '0;
      end else begin
         if (uop.ld_mar) mar <= bus[ADDR_W-1:0];
         if (uop.ld_ir)  ir  <= bus[DATA_W-1 -: OP_W];
         if (uop.ld_pc && !(uop.br_nz && zf)) pc <= bus[ADDR_W-1:0];
         else if (uop.inc_pc)                 pc <= pc + 1'b1;
         if (uop.mdr_mem)      mdr <= mem_rdata;
         else if (uop.mdr_bus) mdr <= bus;
         else if (uop.mdr_dec) mdr <= mdr - 1'b1;
         if (uop.ld_acc) acc <= alu_y;
         if (uop.ld_z)   zf  <= (alu_y == '0);
      end
   end

   assign mem_addr  = mar;
   assign mem_wdata = mdr;
   assign opcode    = ir;

   p_one_driver_r10: assert property (@(posedge clk) disable iff (rst)
      $onehot0(uop.oe));
   p_rd_wr_excl_r10: assert property (@(posedge clk) disable iff (rst)
      !(uop.rd && uop.wr));
   p_pc_step_r2: assert property (@(posedge clk) disable iff (rst)
      uop.inc_pc |=> pc == ADDR_W'($past(pc) + 1'b1));
   p_zero_track_r5: assert property (@(posedge clk) disable iff (rst)
      uop.ld_z |=> zf == (acc == '0));
   p_zero_hold_r5: assert property (@(posedge clk) disable iff (rst)
      !uop.ld_z |=> $stable(zf));
   p_branch_hold_r6: assert property (@(posedge clk) disable iff (rst)
      (uop.ld_pc && uop.br_nz && zf) |=> $stable(pc));
   p_ptr_dec_r8: assert property (@(posedge clk) disable iff (rst)
      uop.mdr_dec |=> mdr == DATA_W'($past(mdr) - 1'b1));
   p_done_no_write_r9: assert property (@(posedge clk) disable iff (rst)
      (uop.done && !uop.ld_acc && !uop.ld_pc) |-> !uop.rd);

endmodule

// File: rtl/acc_core.sv
module acc_core
   import acc_core_pkg::*;
#(
   parameter  int DATA_W = 16,
   localparam int ADDR_W = DATA_W - OP_W
) (
   input  logic              clk,
   input  logic              rst,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              mem_rd,
   output logic              mem_wr
);

   generate
      if (DATA_W < OP_W + 4) begin : g_bad_width
         $error("acc_core: DATA_W must leave at least 4 address bits");
      end
   endgenerate

   uop_t            uop;
   logic [OP_W-1:0] opcode;

   acc_core_ctrl u_ctrl (
      .clk    (clk),
      .rst    (rst),
      .opcode (opcode),
      .uop    (uop)
   );

   acc_core_dp #(.DATA_W(DATA_W)) u_dp (
      .clk       (clk),
      .rst       (rst),
      .uop       (uop),
      .mem_rdata (mem_rdata),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .opcode    (opcode)
   );

   assign mem_rd = uop.rd;
   assign mem_wr = uop.wr;

endmodule

// File: tb/acc_core_test.sv
module acc_core_test;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [11:0] mem_addr;
   logic [15:0] mem_rdata, mem_wdata;
   logic        mem_rd, mem_wr;

   int checks = 0;
   int fails  = 0;

   logic [15:0] mem [256];

   always #2 clk = ~clk;

   acc_core uut (
      .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
      .mem_wdata(mem_wdata), .mem_rd(mem_rd), .mem_wr(mem_wr)
   );

   assign mem_rdata = mem[mem_addr[7:0]];
   always @(posedge clk) if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;

   // cycle index since reset release, plus first-access capture
   int cyc;
   int wr_cyc, rd_cyc, rd_addr, wr_addr, wr_data, rst_strobe;
   always @(posedge clk) cyc <= rst ? 0 : cyc + 1;
   always @(negedge clk) begin
      if (rst) begin
         wr_cyc <= -1; rd_cyc <= -1;
         if (mem_rd || mem_wr) rst_strobe <= 1;
      end else begin
         if (mem_wr && wr_cyc < 0) begin
            wr_cyc <= cyc; wr_addr <= int'(mem_addr); wr_data <= int'(mem_wdata);
         end
         if (mem_rd && rd_cyc < 0) begin
            rd_cyc <= cyc; rd_addr <= int'(mem_addr);
         end
      end
   end

   function automatic logic [15:0] ins(input int op, input int adr);
      return {op[3:0], adr[11:0]};
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic start();
      @(posedge clk); #1 rst = 1'b1;
      rst_strobe = 0;
      for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
   endtask

   task automatic go(input int n);
      @(posedge clk); @(posedge clk); #1 rst = 1'b0;
      repeat (n) @(negedge clk);
   endtask

   task automatic t_load_store();
      start();
      mem[0] = ins(0, 'h80); mem[1] = ins(1, 'h81); mem[2] = ins(6, 2);
      mem['h80] = 16'h1234;
      go(40);
      chk("R1 no strobe in reset", rst_strobe, 0);
      chk("R1 first read cycle", rd_cyc, 1);
      chk("R1 first read addr", rd_addr, 0);
      chk("R3 store write cycle", wr_cyc, 9);
      chk("R3 store addr", wr_addr, 'h81);
      chk("R2 R3 stored value", int'(mem['h81]), 'h1234);
   endtask

   task automatic t_arith();
      logic [15:0] a;
      start();
      mem[0] = ins(0, 'h80); mem[1] = ins(2, 'h81); mem[2] = ins(1, 'h90);
      mem[3] = ins(3, 'h82); mem[4] = ins(1, 'h91); mem[5] = ins(4, 'h83);
      mem[6] = ins(1, 'h92); mem[7] = ins(5, 0);    mem[8] = ins(1, 'h93);
      mem[9] = ins(6, 9);
      mem['h80] = 16'hFFF0; mem['h81] = 16'h0020;
      mem['h82] = 16'h0011; mem['h83] = 16'h0F0F;
      go(120);
      a = 16'hFFF0 + 16'h0020;
      chk("R4 add wraps", int'(mem['h90]), int'(a));
      a = a - 16'h0011;
      chk("R4 sub", int'(mem['h91]), int'(a));
      a = ~(a & 16'h0F0F);
      chk("R4 nand", int'(mem['h92]), int'(a));
      a = {a[14:0], 1'b0};
      chk("R4 shift left", int'(mem['h93]), int'(a));
   endtask

   task automatic t_branch();
      start();
      mem[0]  = ins(0, 'h80); mem[1]  = ins(3, 'h81); mem[2]  = ins(7, 1);
      mem[3]  = ins(1, 'h90); mem[4]  = ins(0, 'h82); mem[5]  = ins(7, 8);
      mem[6]  = ins(1, 'h91); mem[7]  = ins(6, 9);    mem[8]  = ins(1, 'h92);
      mem[9]  = ins(5, 0);    mem[10] = ins(7, 12);   mem[11] = ins(1, 'h93);
      mem[12] = ins(6, 12);
      mem['h80] = 16'd3; mem['h81] = 16'd1; mem['h82] = 16'd5;
      mem['h90] = 16'hAAAA; mem['h92] = 16'hDEAD; mem['h93] = 16'hBEEF;
      go(200);
      chk("R6 R5 loop ran to zero", int'(mem['h90]), 0);
      chk("R5 load keeps zero, branch not taken", int'(mem['h91]), 5);
      chk("R6 jump skipped store", int'(mem['h92]), 'hDEAD);
      chk("R6 R5 shift clears zero, branch taken", int'(mem['h93]), 'hBEEF);
   endtask

   task automatic t_indirect();
      start();
      mem[0] = ins(8, 'h80); mem[1] = ins(1, 'h90); mem[2] = ins(6, 2);
      mem['h80] = 16'h0085; mem['h85] = 16'h4321;
      go(40);
      chk("R7 indirect load", int'(mem['h90]), 'h4321);
      chk("R7 pointer untouched", int'(mem['h80]), 'h85);
   endtask

   task automatic t_predec();
      start();
      mem[0] = ins(9, 'h80); mem[1] = ins(1, 'h90); mem[2] = ins(9, 'h80);
      mem[3] = ins(1, 'h91); mem[4] = ins(6, 4);
      mem['h80] = 16'h0086; mem['h84] = 16'h7777;
      mem['h85] = 16'h5A5A; mem['h86] = 16'h1111;
      go(80);
      chk("R8 writeback cycle", wr_cyc, 5);
      chk("R8 writeback addr", wr_addr, 'h80);
      chk("R8 writeback value", wr_data, 'h85);
      chk("R8 first operand", int'(mem['h90]), 'h5A5A);
      chk("R8 second operand", int'(mem['h91]), 'h7777);
      chk("R8 pointer final", int'(mem['h80]), 'h84);
   endtask

   task automatic t_undef();
      start();
      mem[0] = ins(0, 'h80); mem[1] = 16'hA000; mem[2] = 16'hF081;
      mem[3] = ins(1, 'h90); mem[4] = ins(6, 4);
      mem['h80] = 16'h00AB; mem['h81] = 16'h0055;
      go(60);
      chk("R9 no-op timing", wr_cyc, 17);
      chk("R9 accumulator kept", int'(mem['h90]), 'hAB);
      chk("R9 operand untouched", int'(mem['h81]), 'h55);
   endtask

   initial begin
      #(4 * 150000);
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      t_load_store();
      t_arith();
      t_branch();
      t_indirect();
      t_predec();
      t_undef();
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule